// File: doc/BRIEF.md
# Auxiliary Platform Control Register Block

This block is a small memory-mapped slave that gathers miscellaneous platform controls behind one simple register bus. The bus carries an address, an access size (byte, halfword or word), a write strobe and write data. Read data is returned combinationally for the addressed register. The block holds plain byte registers for configuration, diagnostics and modem control. It also has an auxiliary-function byte, a power-down control byte, a 16-bit LED register and a 32-bit system-control register.

Several registers have side effects on write. Setting the terminal-count bit of the auxiliary-function byte emits a one-cycle pulse, and the bit is never stored. The power-down byte carries a sticky power-fail flag. That flag is set from a synchronized power-failing input when the power-interrupt enable is on, and it is cleared by a write-one bit. Writing the power-off bit requests a shutdown. A system-control write with its low bit set records a reset-status value and requests a system reset. Any write to the halt location raises a CPU halt request, which holds until reset. Reset clears only part of the state, so the diagnostic byte and the reset-status value survive it.

Top module: `auxctl_top`

## Requirements
- R1: `pf_irq_o` is 1 exactly when the power-fail flag (power-down byte bit 5) and the power-interrupt enable (configuration bit 3) are both 1.
- R2: The power-failing input passes through a two-flop synchronizer. Each change of the synchronized value updates the flag to (input AND configuration bit 3), and the result shows on the third clock edge after the input changes.
- R3: A byte write to the auxiliary-function byte (address 0x3) with data bit 1 set pulses `tc_pulse_o` in the cycle after the write. The byte stores the data with bit 1 forced to 0.
- R4: A byte write to the power-down byte (address 0x4) keeps only data bits 0 and 1, and it preserves the flag. If data bit 1 is set, the flag is cleared and only bit 0 remains. Data bit 0 is stored and also pulses `shutdown_req_o`.
- R5: A word write to the system-control window (addresses 0xC to 0xF) at 0xC with data bit 0 set loads 0x00000002 and pulses `sysreset_req_o`. Word writes there without bit 0 set change nothing. Word reads at 0xD to 0xF return 0.
- R6: Reset clears configuration, modem control, the auxiliary-function byte, the power-down byte and the halt request. It leaves the diagnostic byte and the system-control register unchanged.
- R7: Any byte write to address 0x5 raises `cpu_halt_o`, which stays at 1 until reset. A read at 0x5 returns 0.
- R8: Configuration (0x0), diagnostic (0x1) and modem-control (0x2) are 8-bit read/write byte registers. The LED register is 16-bit read/write at halfword address 0x8, and a halfword access at 0x9 reads 0 and is ignored on write.
- R9: An access whose size does not match the register (size code 0 byte, 1 halfword, 2 word), or one to an unmapped address, is ignored on write and reads 0.
- R10: `tc_pulse_o`, `shutdown_req_o` and `sysreset_req_o` are each high for one cycle per triggering write. With no write they are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data, right-aligned |
| bus_rdata | output | DATA_W | Read data for the addressed register, zero-extended |
| pwr_failing_i | input | 1 | Asynchronous power-failing status |
| pf_irq_o | output | 1 | Power-fail interrupt |
| tc_pulse_o | output | 1 | Terminal-count pulse |
| shutdown_req_o | output | 1 | Shutdown request pulse |
| sysreset_req_o | output | 1 | System reset request pulse |
| cpu_halt_o | output | 1 | CPU halt request, held until reset |

## Verification
The assertions assume that `bus_we` stays low while reset is asserted. They also assume that a write lasts exactly one cycle with address, size and data stable in that cycle. The power-down assertions treat a synchronized input change as winning over a same-cycle register write for the flag. The bench keeps `bus_we` low during reset and leaves the power-failing input still across power-down writes. After each input change it waits four cycles, so every flag transition comes from a single cause the checks can attribute.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_DIAG,
        SEL_MODEM,
        SEL_AUX,
        SEL_PDOWN,
        SEL_HALT,
        SEL_LED,
        SEL_SYS
    } reg_sel_e;

    // bit positions with behaviour attached
    localparam int CFG_PIE_BIT  = 3;
    localparam int AUX_TC_BIT   = 1;
    localparam int PD_OFF_BIT   = 0;
    localparam int PD_CLR_BIT   = 1;
    localparam int PD_FLAG_BIT  = 5;
    localparam int SYS_RST_BIT  = 0;
    localparam logic [7:0] SYS_RST_STATUS = 8'h02;

    // local map width
    localparam int MAP_BITS = 4;

endpackage

// File: rtl/auxctl_sync.sv
module auxctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/auxctl_decode.sv
module auxctl_decode
    import auxctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output reg_sel_e          sel_o,
    output logic              off_zero_o
);
    logic hi_ok;
    logic [MAP_BITS-1:0] loc;

    generate
        if (ADDR_W > MAP_BITS) begin : g_wide
            assign hi_ok = ~|addr_i[ADDR_W-1:MAP_BITS];
        end else begin : g_narrow
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign loc = addr_i[MAP_BITS-1:0];

    always_comb begin
        sel_o      = SEL_NONE;
        off_zero_o = 1'b1;
        if (hi_ok) begin
            case (loc)
                4'h0: if (size_i == SZ_BYTE) sel_o = SEL_CFG;
                4'h1: if (size_i == SZ_BYTE) sel_o = SEL_DIAG;
                4'h2: if (size_i == SZ_BYTE) sel_o = SEL_MODEM;
                4'h3: if (size_i == SZ_BYTE) sel_o = SEL_AUX;
                4'h4: if (size_i == SZ_BYTE) sel_o = SEL_PDOWN;
                4'h5: if (size_i == SZ_BYTE) sel_o = SEL_HALT;
                4'h8, 4'h9: begin
                    if (size_i == SZ_HALF) sel_o = SEL_LED;
                    off_zero_o = ~loc[0];
                end
                4'hC, 4'hD, 4'hE, 4'hF: begin
                    if (size_i == SZ_WORD) sel_o = SEL_SYS;
                    off_zero_o = (loc[1:0] == 2'b00);
                end
                default: sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/auxctl_pdown.sv
module auxctl_pdown
    import auxctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       pf_sync_i,
    input  logic       pie_i,
    output logic       flag_o,
    output logic       off_o,
    output logic       shutdown_o
);
    typedef struct packed {
        logic off;
        logic flag;
        logic pf_prev;
        logic shut;
    } pd_state_t;

    pd_state_t pd_d, pd_q;
    logic      pf_chg;

    always_comb begin
        pd_d         = pd_q;
        pd_d.shut    = 1'b0;
        pf_chg       = (pf_sync_i != pd_q.pf_prev);
        pd_d.pf_prev = pf_sync_i;
        if (wr_i) begin
            pd_d.off  = wdata_i[PD_OFF_BIT];
            pd_d.shut = wdata_i[PD_OFF_BIT];
            if (wdata_i[PD_CLR_BIT]) pd_d.flag = 1'b0;
        end
        if (pf_chg) pd_d.flag = pf_sync_i & pie_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign flag_o     = pd_q.flag;
    assign off_o      = pd_q.off;
    assign shutdown_o = pd_q.shut;

    // R2: flag only rises from a synchronized input high while enabled
    p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_q.flag) |-> ($past(pie_i) && $past(pf_sync_i)));

    // R2/R4: flag only falls through an input change or a register write
    p_flag_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_q.flag) |-> ($past(wr_i) || $past(pf_sync_i != pd_q.pf_prev)));

    // R4: interrupt-clear write with no concurrent input change drops the flag
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i && wdata_i[PD_CLR_BIT] && (pf_sync_i == pd_q.pf_prev)) |-> !pd_q.flag);

    // R10: shutdown pulse always traces to a power-off write
    p_shut_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q.shut |-> $past(wr_i && wdata_i[PD_OFF_BIT]));
endmodule

// File: rtl/auxctl_top.sv
module auxctl_top
    import auxctl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int LED_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_failing_i,
    output logic              pf_irq_o,
    output logic              tc_pulse_o,
    output logic              shutdown_req_o,
    output logic              sysreset_req_o,
    output logic              cpu_halt_o
);
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] modem;
        logic [BYTE_W-1:0] aux;
        logic [LED_W-1:0]  led;
        logic              tc;
        logic              rst_req;
        logic              halt;
    } clr_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] diag;
        logic [DATA_W-1:0] sys;
    } keep_state_t;

    clr_state_t  c_d, c_q;
    keep_state_t k_d, k_q;

    reg_sel_e sel;
    logic     off_zero;
    logic     pf_sync;
    logic     pd_flag, pd_off, pd_shut;
    logic     wr_pdown;

    auxctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i     (bus_addr),
        .size_i     (bus_size),
        .sel_o      (sel),
        .off_zero_o (off_zero)
    );

    auxctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwr_failing_i),
        .sync_o  (pf_sync)
    );

    assign wr_pdown = bus_we && (sel == SEL_PDOWN);

    auxctl_pdown u_pdown (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_pdown),
        .wdata_i    (bus_wdata[BYTE_W-1:0]),
        .pf_sync_i  (pf_sync),
        .pie_i      (c_q.cfg[CFG_PIE_BIT]),
        .flag_o     (pd_flag),
        .off_o      (pd_off),
        .shutdown_o (pd_shut)
    );

    // next-state computation
    always_comb begin
        c_d         = c_q;
        k_d         = k_q;
        c_d.tc      = 1'b0;
        c_d.rst_req = 1'b0;
        if (bus_we) begin
            case (sel)
                SEL_CFG:   c_d.cfg   = bus_wdata[BYTE_W-1:0];
                SEL_DIAG:  k_d.diag  = bus_wdata[BYTE_W-1:0];
                SEL_MODEM: c_d.modem = bus_wdata[BYTE_W-1:0];
                SEL_AUX: begin
                    c_d.aux             = bus_wdata[BYTE_W-1:0];
                    c_d.aux[AUX_TC_BIT] = 1'b0;
                    c_d.tc              = bus_wdata[AUX_TC_BIT];
                end
                SEL_HALT:  c_d.halt = 1'b1;
                SEL_LED:   if (off_zero) c_d.led = bus_wdata[LED_W-1:0];
                SEL_SYS: begin
                    if (off_zero && bus_wdata[SYS_RST_BIT]) begin
                        k_d.sys     = DATA_W'(SYS_RST_STATUS);
                        c_d.rst_req = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // state that deliberately survives reset
    always_ff @(posedge clk) begin
        k_q <= k_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CFG:   bus_rdata = DATA_W'(c_q.cfg);
            SEL_DIAG:  bus_rdata = DATA_W'(k_q.diag);
            SEL_MODEM: bus_rdata = DATA_W'(c_q.modem);
            SEL_AUX:   bus_rdata = DATA_W'(c_q.aux);
            SEL_PDOWN: begin
                bus_rdata[PD_FLAG_BIT] = pd_flag;
                bus_rdata[PD_OFF_BIT]  = pd_off;
            end
            SEL_LED:   if (off_zero) bus_rdata = DATA_W'(c_q.led);
            SEL_SYS:   if (off_zero) bus_rdata = k_q.sys;
            default:   bus_rdata = '0;
        endcase
    end

    assign pf_irq_o       = pd_flag & c_q.cfg[CFG_PIE_BIT];
    assign tc_pulse_o     = c_q.tc;
    assign shutdown_req_o = pd_shut;
    assign sysreset_req_o = c_q.rst_req;
    assign cpu_halt_o     = c_q.halt;

    // R3: terminal-count pulse follows an auxiliary write with bit 1 set
    p_tc_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse_o |-> $past(bus_we && (sel == SEL_AUX) && bus_wdata[AUX_TC_BIT]));

    // R5: reset request follows a qualifying system-control write
    p_rstreq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req_o |-> $past(bus_we && (sel == SEL_SYS) && off_zero && bus_wdata[SYS_RST_BIT]));

    // R5: after the reset-request write the register holds the status value
    p_sys_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && (sel == SEL_SYS) && off_zero && bus_wdata[SYS_RST_BIT])
        |-> (k_q.sys == DATA_W'(SYS_RST_STATUS)));

    // R7: halt request holds until reset
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt_o |=> cpu_halt_o);

    // R1: interrupt never shows without the enable having been written
    p_irq_needs_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_irq_o) |-> ($past(pf_sync) || $past(bus_we && (sel == SEL_CFG))));
endmodule

// File: tb/auxctl_top_tb_top.sv
module auxctl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwr_failing_i = 1'b0;
    logic        pf_irq_o, tc_pulse_o, shutdown_req_o, sysreset_req_o, cpu_halt_o;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;

    always #5 clk = ~clk;

    auxctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_failing_i(pwr_failing_i), .pf_irq_o(pf_irq_o), .tc_pulse_o(tc_pulse_o),
        .shutdown_req_o(shutdown_req_o), .sysreset_req_o(sysreset_req_o),
        .cpu_halt_o(cpu_halt_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] v);
        bus_we = 1'b0; bus_addr = a; bus_size = s;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_pf(input logic v);
        @(negedge clk);
        pwr_failing_i = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state R6
        rd(4'h0, B, v); chk("R6 cfg after reset", v, 0);
        rd(4'h2, B, v); chk("R6 modem after reset", v, 0);
        rd(4'h3, B, v); chk("R6 aux after reset", v, 0);
        rd(4'h4, B, v); chk("R6 pdown after reset", v, 0);
        chk("R6 halt after reset", cpu_halt_o, 0);
        chk("R10 pulses idle", {tc_pulse_o, shutdown_req_o, sysreset_req_o}, 0);

        // R8 byte register sweeps
        for (int i = 0; i < 256; i++) begin
            wr(4'h0, B, 32'(i) | 32'hFFFF_FF00); rd(4'h0, B, v); chk("R8 cfg", v, 32'(i));
            wr(4'h1, B, 32'(255 - i));           rd(4'h1, B, v); chk("R8 diag", v, 32'(255 - i));
            wr(4'h2, B, 32'(i ^ 8'h5A));         rd(4'h2, B, v); chk("R8 modem", v, 32'(i ^ 8'h5A));
        end
        wr(4'h0, B, 0);

        // R3 aux sweep with pulse and bit-1 masking, R10 pulse width
        for (int i = 0; i < 256; i++) begin
            wr(4'h3, B, 32'(i));
            chk("R3 tc pulse", tc_pulse_o, 32'((i >> 1) & 1));
            rd(4'h3, B, v); chk("R3 aux readback", v, 32'(i & 8'hFD));
            @(negedge clk);
            chk("R10 tc one cycle", tc_pulse_o, 0);
        end

        // R8 LED
        for (int i = 0; i < 64; i++) begin
            wr(4'h8, H, 32'(i * 1031));
            rd(4'h8, H, v); chk("R8 led", v, 32'((i * 1031) & 16'hFFFF));
        end
        wr(4'h9, H, 32'h1234); rd(4'h8, H, v); chk("R8 led offset write ignored", v, 32'((63 * 1031) & 16'hFFFF));
        rd(4'h9, H, v); chk("R8 led offset read", v, 0);

        // R2/R1 power-fail flag and interrupt
        set_pf(1'b1);
        rd(4'h4, B, v); chk("R2 no flag without enable", v, 0);
        chk("R1 irq low", pf_irq_o, 0);
        set_pf(1'b0);
        wr(4'h0, B, 32'h08);
        @(negedge clk); pwr_failing_i = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(4'h4, B, v); chk("R2 flag not yet at edge 2", v, 0);
        @(negedge clk);
        rd(4'h4, B, v); chk("R2 flag at edge 3", v, 32'h20);
        chk("R1 irq high", pf_irq_o, 1);
        wr(4'h0, B, 32'h00);
        chk("R1 irq follows enable", pf_irq_o, 0);
        rd(4'h4, B, v); chk("R1 flag kept after cfg write", v, 32'h20);
        wr(4'h0, B, 32'h08);
        chk("R1 irq back", pf_irq_o, 1);

        // R4 power-down writes
        wr(4'h4, B, 32'hFC); rd(4'h4, B, v); chk("R4 mask keeps flag", v, 32'h20);
        chk("R10 no shutdown", shutdown_req_o, 0);
        wr(4'h4, B, 32'h01);
        chk("R4 shutdown pulse", shutdown_req_o, 1);
        rd(4'h4, B, v); chk("R4 off plus flag", v, 32'h21);
        @(negedge clk); chk("R10 shutdown one cycle", shutdown_req_o, 0);
        wr(4'h4, B, 32'h03); rd(4'h4, B, v); chk("R4 clear keeps off", v, 32'h01);
        chk("R1 irq cleared", pf_irq_o, 0);
        set_pf(1'b0); set_pf(1'b1);
        rd(4'h4, B, v); chk("R2 flag re-set", v, 32'h21);
        wr(4'h4, B, 32'h02); rd(4'h4, B, v); chk("R4 clear all", v, 0);
        set_pf(1'b0);
        rd(4'h4, B, v); chk("R2 low input keeps clear", v, 0);

        // R9 wrong widths and unmapped
        wr(4'h1, B, 32'hA5);
        wr(4'h1, H, 32'h11); wr(4'h1, W, 32'h22);
        rd(4'h1, B, v); chk("R9 diag wrong-size write", v, 32'hA5);
        rd(4'h1, H, v); chk("R9 diag halfword read", v, 0);
        rd(4'h1, W, v); chk("R9 diag word read", v, 0);
        wr(4'h8, B, 32'h77); rd(4'h8, H, v); chk("R9 led byte write", v, 32'((63 * 1031) & 16'hFFFF));
        rd(4'h8, W, v); chk("R9 led word read", v, 0);
        wr(4'h5, H, 0); chk("R9 halt wrong size", cpu_halt_o, 0);
        wr(4'hC, B, 32'h1); chk("R9 sys byte write", sysreset_req_o, 0);
        rd(4'h6, B, v); chk("R9 unmapped read", v, 0);

        // R5 system control
        wr(4'hC, W, 32'hFFFF_FFFE); chk("R5 no request without bit0", sysreset_req_o, 0);
        wr(4'hD, W, 32'h1); chk("R5 offset write ignored", sysreset_req_o, 0);
        wr(4'hC, W, 32'h1); chk("R5 reset request", sysreset_req_o, 1);
        rd(4'hC, W, v); chk("R5 status value", v, 32'h2);
        @(negedge clk); chk("R10 reset req one cycle", sysreset_req_o, 0);
        wr(4'hC, W, 32'hFFFF_FFFE); rd(4'hC, W, v); chk("R5 write without bit0", v, 32'h2);
        rd(4'hD, W, v); chk("R5 offset read", v, 0);
        rd(4'hF, W, v); chk("R5 offset read hi", v, 0);

        // R7 halt
        wr(4'h5, B, 32'h00); chk("R7 halt raised", cpu_halt_o, 1);
        repeat (5) @(negedge clk);
        chk("R7 halt held", cpu_halt_o, 1);
        rd(4'h5, B, v); chk("R7 halt reads zero", v, 0);

        // R6 partial reset
        wr(4'h0, B, 32'h0F); wr(4'h2, B, 32'h3C); wr(4'h3, B, 32'h81); wr(4'h4, B, 32'h01);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rd(4'h0, B, v); chk("R6 cfg cleared", v, 0);
        rd(4'h2, B, v); chk("R6 modem cleared", v, 0);
        rd(4'h3, B, v); chk("R6 aux cleared", v, 0);
        rd(4'h4, B, v); chk("R6 pdown cleared", v, 0);
        rd(4'h1, B, v); chk("R6 diag kept", v, 32'hA5);
        rd(4'hC, W, v); chk("R6 sys status kept", v, 32'h2);
        chk("R6 halt cleared", cpu_halt_o, 0);
        rd(4'h8, H, v); chk("R6 led cleared", v, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule